// File: doc/BRIEF.md
# Write-Once Byte Memory with Control-Pin Mode Decoding

This block models a byte-wide memory that is written once and erased as a whole, and it is meant to sit where a boot or table store of that kind would sit. Each clock cycle it reads three active-low control pins and two high-voltage flags and turns them into one operating mode. The modes are read, output disable, standby, program, program verify, program inhibit and identifier readout. The mode sets whether the byte output is driven and what it carries. The output-drive flag stands in for a tri-state buffer, so an enclosing design can resolve a shared bus from it.

A program operation can only pull stored bits from 1 to 0. The new word is the old word ANDed with the input byte. The write happens on the first clock edge of a program-mode stretch, and the block leaves program mode before it writes again. When the high-voltage flag on address bit 9 is raised, the two identifier bytes take the place of the array. A test-only clear input brings every cell back to the erased state.

Top module: `eprom_model`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0 and `a9_hv`=0, `dout_en` is 1 and `dout` equals the stored byte at `addr`.
- R3: With `ce_n`=1, `dout_en` is 0 whatever `oe_n`, `pgm_n` or the flags are.
- R4: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0.
- R5: A program write stores old AND `din`, so a bit that reads 0 never reads 1 again unless the test clear is applied.
- R6: Exactly one write happens per program-mode stretch, on its first rising edge. Changing `din` while program mode is held has no effect.
- R7: A write happens only when `vpp_on`=1, `ce_n`=0, `pgm_n`=0 and `oe_n`=1. With `ce_n`=1 (inhibit) or `vpp_on`=0 the array is unchanged.
- R8: With `vpp_on`=1, `ce_n`=0 and `oe_n`=0 (verify), `dout` carries the stored byte with `dout_en`=1.
- R9: With `a9_hv`=1, `ce_n`=0 and `oe_n`=0, `dout` is 0x01 when `addr[0]`=0 and 0x0E when `addr[0]`=1. All other address bits are ignored, and this takes precedence over the array and `vpp_on`.
- R10: Both identifier bytes have odd parity over all eight bits, with bit 7 acting as the parity bit.
- R11: `erase_tst`=1 at a rising edge sets every location to 0xFF, and it takes precedence over a program write in the same cycle.
- R12: Whenever `dout_en` is 0, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program enable |
| vpp_on | input | 1 | Programming voltage present |
| a9_hv | input | 1 | High voltage on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Program data |
| erase_tst | input | 1 | Test-only clear of the whole array |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Output-drive enable |

## Verification
The properties assume that every control pin and flag has a known value once reset has been released, and that inputs change only between rising edges. The one-bit-never-rises property compares two reads of the same address, so it also assumes that no clear lands between those two reads. The bench changes every input one nanosecond after a rising edge, holds it for the whole cycle, and keeps all stimulus at defined 0/1 values. That includes the pseudo-random phase, which biases chip enable low so that the program and identifier modes come up often.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_INHIBIT,
    M_OFF,
    M_READ,
    M_VERIFY,
    M_PROGRAM,
    M_IDENT
  } eprom_mode_e;

  // Control pins -> operating mode
  function automatic eprom_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                              input logic pgm_n, input logic vpp_on,
                                              input logic a9_hv);
    if (ce_n) return vpp_on ? M_INHIBIT : M_STANDBY;
    if (!oe_n) begin
      if (a9_hv) return M_IDENT;
      return vpp_on ? M_VERIFY : M_READ;
    end
    if (vpp_on && !pgm_n) return M_PROGRAM;
    return M_OFF;
  endfunction

  function automatic logic mode_drives(input eprom_mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
  endfunction

  // Programming only pulls bits low
  function automatic logic [BYTE_W-1:0] burn(input logic [BYTE_W-1:0] old_b,
                                             input logic [BYTE_W-1:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic sel,
                                                input logic [BYTE_W-1:0] mfg,
                                                input logic [BYTE_W-1:0] dev);
    return sel ? dev : mfg;
  endfunction
endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        pgm_n,
  input  logic        vpp_on,
  input  logic        a9_hv,
  output eprom_mode_e mode,
  output logic        drive,
  output logic        prog_mode
);
  always_comb begin
    mode      = decode_mode(ce_n, oe_n, pgm_n, vpp_on, a9_hv);
    drive     = mode_drives(mode);
    prog_mode = (mode == M_PROGRAM);
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= burn(cells[addr], din);
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/eprom_out_sel.sv
module eprom_out_sel
  import eprom_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFG_ID = 8'h01,
  parameter logic [BYTE_W-1:0] DEV_ID = 8'h0E
) (
  input  eprom_mode_e       mode,
  input  logic              drive,
  input  logic              id_sel,
  input  logic [BYTE_W-1:0] cell_data,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en
);
  always_comb begin
    dout_en = drive;
    if (!drive)              dout = '0;
    else if (mode == M_IDENT) dout = id_byte(id_sel, MFG_ID, DEV_ID);
    else                     dout = cell_data;
  end
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [7:0] MFG_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_on,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              erase_tst,
  output logic [7:0]        dout,
  output logic              dout_en
);
  eprom_mode_e mode;
  logic        drive;
  logic        prog_mode;
  logic        prog_armed_q;
  logic        wr_fire;
  logic [7:0]  cell_data;

  eprom_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_on(vpp_on), .a9_hv(a9_hv),
    .mode(mode), .drive(drive), .prog_mode(prog_mode)
  );

  // One write per program stretch: armed after the entry edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_armed_q <= 1'b0;
    else        prog_armed_q <= prog_mode;
  end

  assign wr_fire = prog_mode && !prog_armed_q && !erase_tst;

  eprom_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .erase(erase_tst), .wr_en(wr_fire),
    .addr(addr), .din(din), .rd_data(cell_data)
  );

  eprom_out_sel #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_out (
    .mode(mode), .drive(drive), .id_sel(addr[0]), .cell_data(cell_data),
    .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_on,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic              erase_tst,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              wr_fire
);
  p_read_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |-> dout_en);

  p_standby_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

  p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> !dout_en);

  p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !a9_hv && $past(rst_n) && $past(!ce_n && !oe_n && !a9_hv)
     && ($past(addr) == addr) && !$past(erase_tst))
    |-> ((dout & ~$past(dout)) == 8'h00));

  p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  p_write_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (vpp_on && !ce_n && !pgm_n && oe_n && !erase_tst));

  p_id_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && a9_hv) |-> (^dout));

  p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00));
endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
  .vpp_on(vpp_on), .a9_hv(a9_hv), .addr(addr), .erase_tst(erase_tst),
  .dout(dout), .dout_en(dout_en), .wr_fire(wr_fire)
);

// File: tb/eprom_model_tb.sv
module eprom_model_tb;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, a9_hv = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic erase_tst = 1'b0;
  logic [7:0] dout;
  logic dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] ref_mem [DEPTH];
  bit ref_armed;
  logic [7:0] last_dout;
  logic last_en;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  eprom_model #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_on(vpp_on), .a9_hv(a9_hv), .addr(addr), .din(din),
    .erase_tst(erase_tst), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got en/data %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: drive, compare against the behavioural model, advance the model
  task automatic cyc(input logic c, input logic o, input logic p, input logic v,
                     input logic h, input logic [ADDR_W-1:0] a,
                     input logic [7:0] d, input logic er);
    logic [7:0] exp_d;
    logic exp_en;
    string tag;
    bit fire;
    ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; a9_hv = h; addr = a; din = d;
    erase_tst = er;
    @(negedge clk);
    if (c) begin exp_en = 0; exp_d = 8'h00; tag = "R3"; end
    else if (o) begin exp_en = 0; exp_d = 8'h00; tag = "R4"; end
    else if (h) begin exp_en = 1; exp_d = a[0] ? 8'h0E : 8'h01; tag = "R9"; end
    else begin exp_en = 1; exp_d = ref_mem[a]; tag = v ? "R8" : "R2"; end
    last_dout = dout;
    last_en = dout_en;
    check(tag, {dout_en, dout}, {exp_en, exp_d});
    @(posedge clk);
    fire = v && !c && !p && o;
    if (er) begin
      foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
    end else if (fire && !ref_armed) begin
      ref_mem[a] = ref_mem[a] & d;
    end
    ref_armed = fire;
    #1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00, 1'b0);
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
    ref_armed = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: erased after reset
    rd('0);             check("R1", {last_en, last_dout}, 9'h1FF);
    rd(DEPTH - 1);      check("R1", {last_en, last_dout}, 9'h1FF);

    // R3: standby and inhibit float regardless of oe_n
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd3, 8'h00, 1'b0);
    check("R3", {last_en, last_dout}, 9'h000);
    // R7: inhibit (ce_n high, program pins otherwise valid) leaves array alone
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd3, 8'h00, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd3, 8'h00, 1'b0);
    rd(10'd3);          check("R7", {last_en, last_dout}, 9'h1FF);
    // R7: no programming voltage, no write
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd4, 8'h00, 1'b0);
    idle();
    rd(10'd4);          check("R7", {last_en, last_dout}, 9'h1FF);

    // R4/R12: output disable
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd4, 8'h00, 1'b0);
    check("R12", {last_en, last_dout}, 9'h000);

    // R5/R6: program, then change din while held
    prog(10'd5, 8'hA5);
    prog(10'd5, 8'h00);
    prog(10'd5, 8'h00);
    idle();
    // R8: verify
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 8'h00, 1'b0);
    check("R8", {last_en, last_dout}, 9'h1A5);
    check("R6", {last_en, last_dout}, 9'h1A5);
    // R5: rewrite with ones cannot raise bits
    prog(10'd5, 8'hFF); idle();
    rd(10'd5);          check("R5", {last_en, last_dout}, 9'h1A5);
    prog(10'd5, 8'h5A); idle();
    rd(10'd5);          check("R5", {last_en, last_dout}, 9'h100);

    // R9/R10: identifier bytes, upper address bits ignored
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd0, 8'h00, 1'b0);
    check("R9", {last_en, last_dout}, 9'h101);
    check("R10", {8'h00, ^last_dout}, 9'h001);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 8'h00, 1'b0);
    check("R9", {last_en, last_dout}, 9'h10E);
    check("R10", {8'h00, ^last_dout}, 9'h001);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h3FE, 8'h00, 1'b0);
    check("R9", {last_en, last_dout}, 9'h101);

    // R11: clear wins over a program entry in the same cycle
    prog(10'd7, 8'h0F);  idle();
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd9, 8'h00, 1'b1);
    idle();
    rd(10'd9);          check("R11", {last_en, last_dout}, 9'h1FF);
    rd(10'd7);          check("R11", {last_en, last_dout}, 9'h1FF);
    rd(10'd5);          check("R11", {last_en, last_dout}, 9'h1FF);

    // Pseudo-random sweep against the model
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[0] & lfsr[1], lfsr[2], lfsr[3], lfsr[4] | lfsr[5], lfsr[6] & lfsr[7] & lfsr[8],
          {6'b0, lfsr[12:9]}, lfsr[20:13],
          (lfsr[26:21] == 6'd0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule